// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer with Range-Flushing Insert

This block is a small, fully associative address translation buffer. Each entry maps a virtual range whose size is the 4 KiB base page times a power of four. A single insert command installs an entry. The command presents two 32-bit halves that form a 64-bit base virtual address, and two 64-bit operand words. The first word gives the physical page and a 4-bit size code. The second word gives the attribute and protection bits.

In the cycle it accepts an insert, the block does four things. It aligns the base down to the entry size. It removes every valid entry whose range intersects the new range. It picks a slot and writes the new entry. The entry is usable from the next cycle on, and a done pulse marks that cycle.

A combinational lookup port takes a virtual address. It returns a hit flag, the translated physical address and the stored attribute fields. The instruction/data select only chooses which pair of halves forms the base address. Permission checking is left to the consumer.

Top module: `vtlb_top`

## Requirements
- R1: While reset is low and after it is released, no entry is valid: lk_hit, ins_done, lk_pa and lk_attr are all zero until an insert completes.
- R2: The size code is ins_op1[3:0]; an entry covers 4 KiB shifted left by twice the code (code 0 is 4 KiB, code 1 is 16 KiB, code 15 is 4 TiB).
- R3: When ins_is_data is 1 the base address is {d_space, d_offset}, otherwise {i_space, i_offset}; the base is rounded down to a multiple of the entry size, and the range ends at base plus size minus one.
- R4: The stored physical base is (ins_op1 << 7) with every bit below the entry size cleared; a hit returns that base plus (lk_va minus the range start).
- R5: lk_attr = {op2[61], op2[60], op2[59], op2[58:56], op2[55:54], op2[53:52], op2[51], op2[31:1]} (42 bits, listed MSB first); op2 bits 50, 49, 0 and all other bits have no effect on lk_attr.
- R6: Every valid entry whose range intersects the new range is invalidated in the same cycle as the insert, so a lookup in the old range but outside the new one misses.
- R7: A lookup hits when lk_va lies between a valid entry's start and end, both inclusive; on a miss lk_pa and lk_attr are zero.
- R8: The new entry goes to the lowest-numbered slot that is free after the flush; with no free slot it goes to the slot named by a round-robin pointer, which then advances by one and wraps.
- R9: ins_done is high for exactly the one cycle after an accepted insert, and from that cycle on the lookup port reflects the new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert command strobe |
| ins_is_data | input | 1 | 1 selects the data address pair, 0 the instruction pair |
| d_space | input | 32 | Upper half of the data base address |
| d_offset | input | 32 | Lower half of the data base address |
| i_space | input | 32 | Upper half of the instruction base address |
| i_offset | input | 32 | Lower half of the instruction base address |
| ins_op1 | input | 64 | Physical page and size code |
| ins_op2 | input | 64 | Attribute word |
| ins_done | output | 1 | Insert completed pulse |
| lk_va | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 64 | Translated physical address |
| lk_attr | output | 42 | Attribute fields of the hit entry |

## Verification
The bound checker watches the following on every cycle:
- at most one entry matches any lookup address, which shows the overlap flush works;
- the done pulse tracks the insert strobe exactly;
- the valid set never grows by more than one per insert and stays unchanged between inserts;
- the chosen slot is valid afterwards;
- the round-robin pointer steps only when no slot was free.

Some behaviour only the bench scenarios can show. This covers the translated address arithmetic for each size code, the alignment of unaligned bases, and the inclusive range edges. It also covers which of the two address pairs is used, that the ignored attribute bits leave no trace, and which older entry a full buffer evicts.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

   localparam int ATTR_W = 42;
   localparam int OPW    = 64;

   typedef struct packed {
      logic        trap_en;
      logic        dirty;
      logic        brk;
      logic [2:0]  rights_kind;
      logic [1:0]  priv_lo;
      logic [1:0]  priv_hi;
      logic        uncached;
      logic [30:0] key;
   } tlb_attr_t;

   function automatic tlb_attr_t pick_attr(input logic [OPW-1:0] w);
      tlb_attr_t a;
      a.trap_en     = w[61];
      a.dirty       = w[60];
      a.brk         = w[59];
      a.rights_kind = w[58:56];
      a.priv_lo     = w[55:54];
      a.priv_hi     = w[53:52];
      a.uncached    = w[51];
      a.key         = w[31:1];
      return a;
   endfunction

endpackage

// File: rtl/vtlb_range_calc.sv
module vtlb_range_calc #(
   parameter int ADDR_W    = 64,
   parameter int PAGE_BITS = 12,
   parameter int CODE_W    = 4,
   parameter int PA_SHIFT  = 7
) (
   input  logic [ADDR_W-1:0]  base_va,
   input  logic [ADDR_W-1:0]  op_page,
   output logic [ADDR_W-1:0]  rng_start,
   output logic [ADDR_W-1:0]  rng_last,
   output logic [ADDR_W-1:0]  pa_base
);

   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [CODE_W-1:0]  code;
   logic [ADDR_W-1:0]  low_mask;
   logic [ADDR_W-1:0]  shifted_page;

   always_comb begin
      code         = op_page[CODE_W-1:0];
      low_mask     = (ONE << (PAGE_BITS + 2 * int'(code))) - ONE;
      rng_start    = base_va & ~low_mask;
      rng_last     = rng_start | low_mask;
      shifted_page = op_page << PA_SHIFT;
      pa_base      = shifted_page & ~low_mask;
   end

endmodule

// File: rtl/vtlb_victim_sel.sv
module vtlb_victim_sel #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] occupied,
   input  logic [IDX_W-1:0]   rr_ptr,
   output logic [IDX_W-1:0]   victim,
   output logic               free_any
);

   logic [IDX_W-1:0] first_free;

   always_comb begin
      free_any   = 1'b0;
      first_free = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!occupied[i]) begin
            free_any   = 1'b1;
            first_free = IDX_W'(i);
         end
      end
      victim = free_any ? first_free : rr_ptr;
   end

endmodule

// File: rtl/vtlb_match.sv
module vtlb_match #(
   parameter int ENTRIES  = 16,
   parameter int ADDR_W   = 64,
   parameter bit MASK_CMP = 1'b1,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]             valid,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] starts,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] lasts,
   input  logic [ADDR_W-1:0]              va,
   output logic [ENTRIES-1:0]             hit_vec,
   output logic [IDX_W-1:0]               hit_idx,
   output logic                           hit
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      if (MASK_CMP) begin : g_mask
         // aligned ranges: start^last is exactly the in-range offset mask
         logic [ADDR_W-1:0] span;
         assign span       = starts[g] ^ lasts[g];
         assign hit_vec[g] = valid[g] && ((va & ~span) == starts[g]);
      end else begin : g_mag
         assign hit_vec[g] = valid[g] && (va >= starts[g]) && (va <= lasts[g]);
      end
   end

   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
      hit = |hit_vec;
   end

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
   import vtlb_pkg::*;
#(
   parameter int ENTRIES   = 16,
   parameter int ADDR_W    = 64,
   parameter int PAGE_BITS = 12,
   parameter int CODE_W    = 4,
   parameter int PA_SHIFT  = 7,
   parameter bit MASK_CMP  = 1'b1,
   localparam int HALF_W   = ADDR_W / 2,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ins_valid,
   input  logic               ins_is_data,
   input  logic [HALF_W-1:0]  d_space,
   input  logic [HALF_W-1:0]  d_offset,
   input  logic [HALF_W-1:0]  i_space,
   input  logic [HALF_W-1:0]  i_offset,
   input  logic [ADDR_W-1:0]  ins_op1,
   input  logic [OPW-1:0]     ins_op2,
   output logic               ins_done,
   input  logic [ADDR_W-1:0]  lk_va,
   output logic               lk_hit,
   output logic [ADDR_W-1:0]  lk_pa,
   output logic [ATTR_W-1:0]  lk_attr
);

   initial begin
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0)
         $fatal(1, "ENTRIES must be a power of two, at least 2");
      if (ADDR_W % 2 != 0)
         $fatal(1, "ADDR_W must be even");
      if (PAGE_BITS + 2 * ((1 << CODE_W) - 1) >= ADDR_W)
         $fatal(1, "largest entry size does not fit ADDR_W");
   end

   // entry storage
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][ADDR_W-1:0] start_q;
   logic [ENTRIES-1:0][ADDR_W-1:0] last_q;
   logic [ENTRIES-1:0][ADDR_W-1:0] pa_q;
   tlb_attr_t                      attr_q [ENTRIES];
   logic [IDX_W-1:0]               rr_q;

   // insert path
   logic [ADDR_W-1:0]  base_va;
   logic [ADDR_W-1:0]  new_start;
   logic [ADDR_W-1:0]  new_last;
   logic [ADDR_W-1:0]  new_pa;
   logic [ENTRIES-1:0] ovl;
   logic [ENTRIES-1:0] survivors;
   logic [IDX_W-1:0]   victim;
   logic               free_any;

   assign base_va = ins_is_data ? {d_space, d_offset} : {i_space, i_offset};

   vtlb_range_calc #(
      .ADDR_W   (ADDR_W),
      .PAGE_BITS(PAGE_BITS),
      .CODE_W   (CODE_W),
      .PA_SHIFT (PA_SHIFT)
   ) u_range (
      .base_va  (base_va),
      .op_page  (ins_op1),
      .rng_start(new_start),
      .rng_last (new_last),
      .pa_base  (new_pa)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ovl
      assign ovl[g] = valid_q[g] && (start_q[g] <= new_last) && (last_q[g] >= new_start);
   end

   assign survivors = valid_q & ~ovl;

   vtlb_victim_sel #(
      .ENTRIES(ENTRIES)
   ) u_victim (
      .occupied(survivors),
      .rr_ptr  (rr_q),
      .victim  (victim),
      .free_any(free_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= '0;
         rr_q     <= '0;
         ins_done <= 1'b0;
      end else begin
         ins_done <= ins_valid;
         if (ins_valid) begin
            valid_q         <= survivors | (ENTRIES'(1) << victim);
            start_q[victim] <= new_start;
            last_q[victim]  <= new_last;
            pa_q[victim]    <= new_pa;
            attr_q[victim]  <= pick_attr(ins_op2);
            if (!free_any) rr_q <= rr_q + 1'b1;
         end
      end
   end

   // lookup path
   logic [ENTRIES-1:0] hit_vec;
   logic [IDX_W-1:0]   hit_idx;
   logic               any_hit;

   vtlb_match #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W),
      .MASK_CMP(MASK_CMP)
   ) u_match (
      .valid  (valid_q),
      .starts (start_q),
      .lasts  (last_q),
      .va     (lk_va),
      .hit_vec(hit_vec),
      .hit_idx(hit_idx),
      .hit    (any_hit)
   );

   always_comb begin
      lk_hit  = any_hit;
      lk_pa   = '0;
      lk_attr = '0;
      if (any_hit) begin
         lk_pa   = pa_q[hit_idx] + (lk_va - start_q[hit_idx]);
         lk_attr = attr_q[hit_idx];
      end
   end

endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ins_valid,
   input logic               ins_done,
   input logic               lk_hit,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] hit_vec,
   input logic [IDX_W-1:0]   victim,
   input logic               free_any,
   input logic [IDX_W-1:0]   rr_q
);

   a_r9_done_after_insert: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |=> ins_done);

   a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> !ins_done);

   // R6: the flush leaves no two entries covering one address
   a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r6_growth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |=> $countones(valid_q) <= $past($countones(valid_q)) + 1);

   a_r8_victim_filled: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |=> valid_q[$past(victim)]);

   a_r8_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !free_any) |=> rr_q == IDX_W'($past(rr_q) + 1'b1));

   a_r8_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_valid || free_any) |=> $stable(rr_q));

   a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> $stable(valid_q));

   a_r7_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q == '0) |-> !lk_hit);

endmodule

bind vtlb_top vtlb_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ins_valid(ins_valid),
   .ins_done (ins_done),
   .lk_hit   (lk_hit),
   .valid_q  (valid_q),
   .hit_vec  (hit_vec),
   .victim   (victim),
   .free_any (free_any),
   .rr_q     (rr_q)
);

// File: tb/tb_vtlb_top.sv
`timescale 1ns/1ps
module tb_vtlb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 1'b0;
   logic        ins_is_data = 1'b0;
   logic [31:0] d_space = '0, d_offset = '0, i_space = '0, i_offset = '0;
   logic [63:0] ins_op1 = '0, ins_op2 = '0, lk_va = '0;
   logic        ins_done, lk_hit;
   logic [63:0] lk_pa;
   logic [41:0] lk_attr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   vtlb_top dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_is_data(ins_is_data),
      .d_space(d_space), .d_offset(d_offset), .i_space(i_space), .i_offset(i_offset),
      .ins_op1(ins_op1), .ins_op2(ins_op2), .ins_done(ins_done),
      .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
   );

   typedef struct packed {
      logic        is_data;
      logic [31:0] sp;
      logic [31:0] off;
      logic [63:0] op1;
      logic [63:0] op2;
      logic [63:0] look;
      logic [63:0] exp_pa;
   } vec_t;

   localparam int NV = 4;
   localparam vec_t VECS [NV] = '{
      // R2 code 0, data pair, unaligned base
      '{1'b1, 32'h0, 32'h0000_5123, 64'h0024_68A0, 64'h2000_0000_0000_0003,
        64'h0000_0000_0000_5123, 64'h0000_0000_1234_5123},
      // R2 code 1, instruction pair
      '{1'b0, 32'h1, 32'h0003_0000, 64'h0024_68A1, 64'h1C53_0000_1234_5678,
        64'h0000_0001_0003_2ABC, 64'h0000_0000_1234_6ABC},
      // code 2 over the first entry (R6)
      '{1'b1, 32'h0, 32'h0000_5800, 64'h0800_0002, 64'h0728_0000_8000_0000,
        64'h0000_0000_0000_5123, 64'h0000_0004_0000_5123},
      // R2 code 15, largest size
      '{1'b1, 32'hDEAD_BEEF, 32'h1234_5678, 64'h0000_000F, 64'h3FF8_0000_FFFF_FFFE,
        64'hDEAD_BEEF_0000_0000, 64'h0000_02EF_0000_0000}
   };

   function automatic logic [41:0] ref_attr(input logic [63:0] w);
      return {w[61], w[60], w[59], w[58:56], w[55:54], w[53:52], w[51], w[31:1]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_ins(input bit is_data, input logic [31:0] sp, input logic [31:0] off,
                         input logic [63:0] op1, input logic [63:0] op2);
      @(negedge clk);
      ins_valid   = 1'b1;
      ins_is_data = is_data;
      if (is_data) begin
         d_space = sp; d_offset = off; i_space = 32'hFFFF_FFFF; i_offset = 32'hFFFF_F000;
      end else begin
         i_space = sp; i_offset = off; d_space = 32'hFFFF_FFFF; d_offset = 32'hFFFF_F000;
      end
      ins_op1 = op1;
      ins_op2 = op2;
      @(negedge clk);
      ins_valid = 1'b0;
      check(ins_done === 1'b1, "R9 done pulse", 64'(ins_done), 64'd1);
   endtask

   task automatic look(input logic [63:0] va, input bit exp_hit, input logic [63:0] exp_pa,
                       input string req);
      lk_va = va;
      #1;
      check(lk_hit === exp_hit, req, 64'(lk_hit), 64'(exp_hit));
      if (exp_hit) check(lk_pa === exp_pa, req, lk_pa, exp_pa);
      else         check(lk_pa === 64'd0 && lk_attr === 42'd0, {req, " R7 miss zero"}, lk_pa, 64'd0);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      lk_va = 64'h0;
      #1;
      check(lk_hit === 1'b0 && ins_done === 1'b0, "R1 reset", 64'(lk_hit), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      look(64'h0, 1'b0, 64'h0, "R1 empty after reset");

      // table walk: R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         do_ins(VECS[v].is_data, VECS[v].sp, VECS[v].off, VECS[v].op1, VECS[v].op2);
         look(VECS[v].look, 1'b1, VECS[v].exp_pa, "R4 vector pa");
         check(lk_attr === ref_attr(VECS[v].op2), "R5 vector attr", 64'(lk_attr),
               64'(ref_attr(VECS[v].op2)));
      end

      // R7 inclusive edges of the 16 KiB instruction entry; R3 alignment
      look(64'h0000_0001_0003_0000, 1'b1, 64'h1234_4000, "R7 start edge");
      look(64'h0000_0001_0003_3FFF, 1'b1, 64'h1234_7FFF, "R7 end edge");
      look(64'h0000_0001_0003_4000, 1'b0, 64'h0, "R7 past end");
      look(64'h0000_0001_0002_FFFF, 1'b0, 64'h0, "R7 before start");
      look(64'hDEAD_BC00_0000_0000, 1'b1, 64'h0, "R3 aligned base of largest");
      look(64'hDEAD_BBFF_FFFF_FFFF, 1'b0, 64'h0, "R3 below largest");

      // R6 small insert inside the 64 KiB entry flushes it
      do_ins(1'b1, 32'h0, 32'h0000_3010, 64'h0010_0000, 64'h0);
      look(64'h0000_0000_0000_5123, 1'b0, 64'h0, "R6 old range flushed");
      look(64'h0000_0000_0000_3010, 1'b1, 64'h0800_0010, "R6 new entry");

      // R5 ignored bits 50, 49, 0
      do_ins(1'b1, 32'h0, 32'h0007_0000, 64'h0, 64'h0006_0000_0000_0001);
      lk_va = 64'h0000_0000_0007_0000;
      #1;
      check(lk_hit === 1'b1 && lk_attr === 42'd0, "R5 ignored bits", 64'(lk_attr), 64'd0);

      // R1 reset clears everything
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      look(64'h0000_0001_0003_0000, 1'b0, 64'h0, "R1 cleared by reset");

      // R8 fill all slots, free slots first
      for (int p = 0; p < 16; p++)
         do_ins(1'b1, 32'h0, 32'h0010_0000 + 32'(p) * 32'h1000, 64'(p) << 5, 64'h0);
      for (int p = 0; p < 16; p++)
         look(64'h0010_0034 + 64'(p) * 64'h1000, 1'b1, 64'(p) * 64'h1000 + 64'h34,
              "R8 all sixteen kept");
      // R8 full: round robin evicts slot 0 then slot 1
      do_ins(1'b1, 32'h0, 32'h0020_0000, 64'h0, 64'h0);
      look(64'h0010_0034, 1'b0, 64'h0, "R8 first eviction");
      look(64'h0010_1034, 1'b1, 64'h1034, "R8 neighbour kept");
      look(64'h0020_0034, 1'b1, 64'h34, "R8 new entry");
      do_ins(1'b1, 32'h0, 32'h0021_0000, 64'h0, 64'h0);
      look(64'h0010_1034, 1'b0, 64'h0, "R8 second eviction");
      look(64'h0010_2034, 1'b1, 64'h2034, "R8 third kept");
      // R6 one 64 KiB insert flushes the remaining fourteen
      do_ins(1'b1, 32'h0, 32'h0010_8000, 64'h0100_0002, 64'h0);
      look(64'h0010_5034, 1'b1, 64'h8000_5034, "R6 multi flush");
      look(64'h0020_0034, 1'b1, 64'h34, "R6 unrelated kept");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule